// File: doc/BRIEF.md
# Static memory strobe generator with slow-clock override

This block drives the control side of an external asynchronous memory bus. The pins are one active-low select per chip-select region, an active-low read strobe, an active-low write strobe, active-low byte-lane selects, the address, and a write data bus with an output enable. A requester starts a single read or write through a request port. The block then runs the access for a programmed number of master clock cycles. When the access is done it returns a one-cycle acknowledge and, for reads, the captured data word.

Each chip-select region has two timing sets, one for reads and one for writes. A set holds five counts: a total cycle length, a select setup and width, and a strobe setup and width. All counts are in master clock cycles. Within an access the cycles are numbered k = 0 .. C-1. A signal with setup S and width P is low while S <= k < S+P.

A power-management input selects a fixed low-clock-rate timing set. This set replaces the programmed values for every region at once, so software does not need to rewrite the timings when the master clock drops to tens of kilohertz. The input is sampled only when an access is accepted. A reset loads every programmed set with the same values as the fixed set.

Top module: `extmem_strobe_gen`

## Requirements
- R1: While reset is held and after it is released, every select, the read strobe and the write strobe are high, the acknowledge is low and the write-data output enable is low.
- R2: In normal mode an accepted access lasts C cycles, where C is the programmed cycle count (0 is treated as 1). The selected region's select is low while select-setup <= k < select-setup+select-width. The direction's strobe is low while strobe-setup <= k < strobe-setup+strobe-width. Nothing is ever low past cycle C-1, the other selects stay high, and the strobe of the other direction stays high.
- R3: A request is accepted at a rising edge where no access is in progress. The acknowledge is high only in the single cycle that follows cycle C-1. Strobes and selects are high in that cycle, and a new request can be accepted at its end.
- R4: With the slow-clock input high at acceptance, a read uses cycle 2, select setup 0 and width 2, and strobe setup 1 and width 1.
- R5: With the slow-clock input high at acceptance, a write uses cycle 3, select setup 0 and width 3, and strobe setup 1 and width 1.
- R6: The fixed slow-clock timing applies to every region, whatever values are programmed.
- R7: The slow-clock input and the programmed values are sampled at acceptance. Changing either during an access leaves that access's waveform unchanged.
- R8: For the whole access, the address equals the requested address and the byte-lane selects equal the inverse of the requested lane mask (bit i low enables lane i).
- R9: During every cycle of a write access, the output enable is high and the write data output equals the requested data. During reads and idle cycles the output enable is low.
- R10: Read data is captured at the rising edge where the read strobe returns high. It is shown on the read data output from the acknowledge cycle and held until the next capture. A read whose strobe never goes low leaves it unchanged.
- R11: Configuration writes address a region by index and a field by code. The codes are: 0 read cycle, 1 read select setup, 2 read select width, 3 read strobe setup, 4 read strobe width, 5 write cycle, 6 write select setup, 7 write select width, 8 write strobe setup, 9 write strobe width. Codes 10 to 15 change nothing.
- R12: After reset, every region's programmed timing equals the fixed slow-clock set for the same direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk_mode_i | input | 1 | High selects the fixed slow-clock timing |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_cs_i | input | $clog2(NUM_CS) | Region index for the configuration write |
| cfg_field_i | input | 4 | Field code (R11) |
| cfg_val_i | input | CNT_W | Count value to store |
| req_i | input | 1 | Access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | $clog2(NUM_CS) | Region to access |
| req_addr_i | input | ADDR_W | Access address |
| req_be_i | input | DATA_W/8 | Byte-lane mask, active high |
| req_wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last captured read data |
| mem_cs_n_o | output | NUM_CS | Active-low region selects |
| mem_rd_n_o | output | 1 | Active-low read strobe |
| mem_wr_n_o | output | 1 | Active-low write strobe |
| mem_addr_o | output | ADDR_W | Bus address |
| mem_be_n_o | output | DATA_W/8 | Active-low byte-lane selects |
| mem_wdata_o | output | DATA_W | Write data toward the memory |
| mem_wdata_oe_o | output | 1 | Write data output enable |
| mem_rdata_i | input | DATA_W | Read data from the memory |

## Verification
All bus pins are registered. Cycle k = 0 of an access is therefore visible in the clock period right after the accepting edge, and the acknowledge appears one period after cycle C-1. The bench drives the request, waits for one rising edge, and then compares every pin at each following falling edge against a waveform it computes from its own copy of the timing registers. It puts a different value on the read data bus in each cycle. This shows the exact edge at which data was captured, which the bench checks in the acknowledge cycle. The acknowledge is also checked to be low again one period later.

// File: rtl/extmem_wave_pkg.sv
package extmem_wave_pkg;

    localparam int CNT_W = 6;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [CNT_W:0]   wcnt_t;

    // One direction's timing: lengths in master clock cycles
    typedef struct packed {
        cnt_t cycle;
        cnt_t sel_setup;
        cnt_t sel_width;
        cnt_t stb_setup;
        cnt_t stb_width;
    } dir_timing_t;

    typedef struct packed {
        dir_timing_t rd;
        dir_timing_t wr;
    } region_timing_t;

    localparam dir_timing_t SLOW_RD = '{cycle: CNT_W'(2), sel_setup: CNT_W'(0),
                                        sel_width: CNT_W'(2), stb_setup: CNT_W'(1),
                                        stb_width: CNT_W'(1)};
    localparam dir_timing_t SLOW_WR = '{cycle: CNT_W'(3), sel_setup: CNT_W'(0),
                                        sel_width: CNT_W'(3), stb_setup: CNT_W'(1),
                                        stb_width: CNT_W'(1)};

    // Field codes of the configuration port
    localparam logic [3:0] F_RD_CYCLE = 4'd0;
    localparam logic [3:0] F_RD_SEL_S = 4'd1;
    localparam logic [3:0] F_RD_SEL_W = 4'd2;
    localparam logic [3:0] F_RD_STB_S = 4'd3;
    localparam logic [3:0] F_RD_STB_W = 4'd4;
    localparam logic [3:0] F_WR_CYCLE = 4'd5;
    localparam logic [3:0] F_WR_SEL_S = 4'd6;
    localparam logic [3:0] F_WR_SEL_W = 4'd7;
    localparam logic [3:0] F_WR_STB_S = 4'd8;
    localparam logic [3:0] F_WR_STB_W = 4'd9;

    function automatic wcnt_t eff_cycle(cnt_t c);
        return (c == '0) ? wcnt_t'(1) : {1'b0, c};
    endfunction

    function automatic logic in_window(cnt_t k, cnt_t setup, cnt_t width);
        wcnt_t kk;
        kk = {1'b0, k};
        return (kk >= {1'b0, setup}) && (kk < ({1'b0, setup} + {1'b0, width}));
    endfunction

endpackage

// File: rtl/extmem_cfg_bank.sv
module extmem_cfg_bank
    import extmem_wave_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic [CS_W-1:0]              cs_i,
    input  logic [3:0]                   field_i,
    input  cnt_t                         val_i,
    output region_timing_t [NUM_CS-1:0]  tab_o
);

    region_timing_t [NUM_CS-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (wr_i && (int'(cs_i) < NUM_CS)) begin
            unique case (field_i)
                F_RD_CYCLE: tab_d[cs_i].rd.cycle     = val_i;
                F_RD_SEL_S: tab_d[cs_i].rd.sel_setup = val_i;
                F_RD_SEL_W: tab_d[cs_i].rd.sel_width = val_i;
                F_RD_STB_S: tab_d[cs_i].rd.stb_setup = val_i;
                F_RD_STB_W: tab_d[cs_i].rd.stb_width = val_i;
                F_WR_CYCLE: tab_d[cs_i].wr.cycle     = val_i;
                F_WR_SEL_S: tab_d[cs_i].wr.sel_setup = val_i;
                F_WR_SEL_W: tab_d[cs_i].wr.sel_width = val_i;
                F_WR_STB_S: tab_d[cs_i].wr.stb_setup = val_i;
                F_WR_STB_W: tab_d[cs_i].wr.stb_width = val_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CS; i++) begin
                tab_q[i] <= '{rd: SLOW_RD, wr: SLOW_WR};
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    assign tab_o = tab_q;

    assert_reserved_code_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (field_i > F_WR_STB_W)) |=> $stable(tab_q));

endmodule

// File: rtl/extmem_timing_sel.sv
module extmem_timing_sel
    import extmem_wave_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  region_timing_t [NUM_CS-1:0] tab_i,
    input  logic                        slow_i,
    input  logic                        we_i,
    input  logic [CS_W-1:0]             cs_i,
    output dir_timing_t                 tim_o
);

    region_timing_t entry;

    always_comb begin
        entry = (int'(cs_i) < NUM_CS) ? tab_i[cs_i] : '{rd: SLOW_RD, wr: SLOW_WR};
        if (slow_i) begin
            tim_o = we_i ? SLOW_WR : SLOW_RD;
        end else begin
            tim_o = we_i ? entry.wr : entry.rd;
        end
    end

endmodule

// File: rtl/extmem_access_engine.sv
module extmem_access_engine
    import extmem_wave_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int BE_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic [CS_W-1:0]   req_cs_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [BE_W-1:0]   req_be_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  dir_timing_t       tim_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BE_W-1:0]   be_n_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              wdata_oe_o
);

    typedef struct packed {
        logic              busy;
        cnt_t              cnt;
        logic              we;
        logic [CS_W-1:0]   cs;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
        dir_timing_t       tim;
        logic [NUM_CS-1:0] cs_n;
        logic              rd_n;
        logic              wr_n;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } eng_state_t;

    eng_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;

        // Sequencing: accept when idle, count, finish after the last cycle
        if (!st_q.busy) begin
            if (req_i) begin
                st_d.busy  = 1'b1;
                st_d.cnt   = '0;
                st_d.we    = req_we_i;
                st_d.cs    = req_cs_i;
                st_d.addr  = req_addr_i;
                st_d.be    = req_be_i;
                st_d.wdata = req_wdata_i;
                st_d.tim   = tim_i;
            end
        end else if (({1'b0, st_q.cnt} + wcnt_t'(1)) >= eff_cycle(st_q.tim.cycle)) begin
            st_d.busy = 1'b0;
            st_d.ack  = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + cnt_t'(1);
        end

        // Pin values for the cycle that starts at the next edge
        st_d.cs_n = '1;
        st_d.rd_n = 1'b1;
        st_d.wr_n = 1'b1;
        if (st_d.busy) begin
            if (in_window(st_d.cnt, st_d.tim.sel_setup, st_d.tim.sel_width)
                && (int'(st_d.cs) < NUM_CS)) begin
                st_d.cs_n[st_d.cs] = 1'b0;
            end
            if (in_window(st_d.cnt, st_d.tim.stb_setup, st_d.tim.stb_width)) begin
                if (st_d.we) st_d.wr_n = 1'b0;
                else         st_d.rd_n = 1'b0;
            end
        end

        // Read data taken at the edge where the read strobe rises
        if (st_q.busy && !st_q.we && !st_q.rd_n && st_d.rd_n) begin
            st_d.rdata = rdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.tim  <= SLOW_RD;
            st_q.cs_n <= '1;
            st_q.rd_n <= 1'b1;
            st_q.wr_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o      = st_q.ack;
    assign rdata_o    = st_q.rdata;
    assign cs_n_o     = st_q.cs_n;
    assign rd_n_o     = st_q.rd_n;
    assign wr_n_o     = st_q.wr_n;
    assign addr_o     = st_q.addr;
    assign be_n_o     = ~st_q.be;
    assign wdata_o    = st_q.wdata;
    assign wdata_oe_o = st_q.busy & st_q.we;

    assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    assert_strobe_inside_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o || !wr_n_o) |-> (st_q.busy && (rd_n_o || wr_n_o)));

    assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    assert_ack_after_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(st_q.busy) && !st_q.busy && cs_n_o == '1));

    assert_timing_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |-> $stable(st_q.tim));

    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |-> ($stable(addr_o) && $stable(be_n_o)));

endmodule

// File: rtl/extmem_strobe_gen.sv
module extmem_strobe_gen
    import extmem_wave_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int BE_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk_mode_i,
    input  logic              cfg_wr_i,
    input  logic [CS_W-1:0]   cfg_cs_i,
    input  logic [3:0]        cfg_field_i,
    input  logic [CNT_W-1:0]  cfg_val_i,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic [CS_W-1:0]   req_cs_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [BE_W-1:0]   req_be_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NUM_CS-1:0] mem_cs_n_o,
    output logic              mem_rd_n_o,
    output logic              mem_wr_n_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BE_W-1:0]   mem_be_n_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_wdata_oe_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);

    region_timing_t [NUM_CS-1:0] tab;
    dir_timing_t                 tim_sel;

    extmem_cfg_bank #(.NUM_CS(NUM_CS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr_i),
        .cs_i    (cfg_cs_i),
        .field_i (cfg_field_i),
        .val_i   (cfg_val_i),
        .tab_o   (tab)
    );

    extmem_timing_sel #(.NUM_CS(NUM_CS)) u_sel (
        .tab_i  (tab),
        .slow_i (slow_clk_mode_i),
        .we_i   (req_we_i),
        .cs_i   (req_cs_i),
        .tim_o  (tim_sel)
    );

    extmem_access_engine #(
        .NUM_CS (NUM_CS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .req_we_i    (req_we_i),
        .req_cs_i    (req_cs_i),
        .req_addr_i  (req_addr_i),
        .req_be_i    (req_be_i),
        .req_wdata_i (req_wdata_i),
        .tim_i       (tim_sel),
        .rdata_i     (mem_rdata_i),
        .ack_o       (ack_o),
        .rdata_o     (rdata_o),
        .cs_n_o      (mem_cs_n_o),
        .rd_n_o      (mem_rd_n_o),
        .wr_n_o      (mem_wr_n_o),
        .addr_o      (mem_addr_o),
        .be_n_o      (mem_be_n_o),
        .wdata_o     (mem_wdata_o),
        .wdata_oe_o  (mem_wdata_oe_o)
    );

endmodule

// File: tb/sim_extmem_strobe_gen.sv
module sim_extmem_strobe_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_cs = '0;
    logic [3:0]  cfg_field = '0;
    logic [5:0]  cfg_val = '0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [23:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        ack;
    logic [31:0] rdata;
    logic [3:0]  cs_n;
    logic        rd_n, wr_n, oe;
    logic [23:0] addr;
    logic [3:0]  be_n;
    logic [31:0] wdata;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int acc_id = 0;
    int sh [4][10];

    always #(CLK_PERIOD / 2) clk = ~clk;

    extmem_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .slow_clk_mode_i(slow),
        .cfg_wr_i(cfg_wr), .cfg_cs_i(cfg_cs), .cfg_field_i(cfg_field), .cfg_val_i(cfg_val),
        .req_i(req), .req_we_i(req_we), .req_cs_i(req_cs), .req_addr_i(req_addr),
        .req_be_i(req_be), .req_wdata_i(req_wdata),
        .ack_o(ack), .rdata_o(rdata), .mem_cs_n_o(cs_n), .mem_rd_n_o(rd_n),
        .mem_wr_n_o(wr_n), .mem_addr_o(addr), .mem_be_n_o(be_n), .mem_wdata_o(wdata),
        .mem_wdata_oe_o(oe), .mem_rdata_i(mem_rdata)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rv(int k);
        return 32'h5A00_0000 | (32'(acc_id & 'hFFFF) << 8) | 32'(k & 'hFF);
    endfunction

    task automatic write_cfg(int cs, int field, int val);
        cfg_wr = 1'b1; cfg_cs = 2'(cs); cfg_field = 4'(field); cfg_val = 6'(val);
        @(negedge clk);
        cfg_wr = 1'b0;
        if (field < 10) sh[cs][field] = val;
    endtask

    // Runs one access and checks every pin in every cycle of it
    task automatic do_access(bit we, int cs, logic [23:0] a, logic [3:0] be,
                             logic [31:0] wd, bit disturb);
        int c, ss, sw, ts, tw, base, last;
        string tag;
        logic [31:0] exp_rd;
        logic [3:0]  exp_cs;
        bit low;
        acc_id++;
        base = we ? 5 : 0;
        if (slow) begin
            c  = we ? 3 : 2; ss = 0; sw = we ? 3 : 2; ts = 1; tw = 1;
            tag = (cs != 0) ? "R6" : (we ? "R5" : "R4");
        end else begin
            c  = sh[cs][base]; ss = sh[cs][base+1]; sw = sh[cs][base+2];
            ts = sh[cs][base+3]; tw = sh[cs][base+4];
            tag = "R2";
        end
        if (disturb) tag = "R7";
        if (c == 0) c = 1;
        last = ((ts + tw) < c ? (ts + tw) : c) - 1;
        exp_rd = rdata;
        req = 1'b1; req_we = we; req_cs = 2'(cs); req_addr = a; req_be = be; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < c; k++) begin
            mem_rdata = rv(k);
            exp_cs = 4'hF;
            if (k >= ss && k < ss + sw) exp_cs[cs] = 1'b0;
            low = (k >= ts) && (k < ts + tw);
            chk(tag, "select", 64'(cs_n), 64'(exp_cs));
            chk(tag, "read strobe", 64'(rd_n), 64'(we ? 1'b1 : !low));
            chk(tag, "write strobe", 64'(wr_n), 64'(we ? !low : 1'b1));
            chk("R8", "addr/lanes", {36'd0, addr, be_n}, {36'd0, a, ~be});
            chk("R9", "data enable", 64'(oe), 64'(we));
            if (we) chk("R9", "write data", 64'(wdata), 64'(wd));
            chk("R3", "ack inside access", 64'(ack), 64'd0);
            if (disturb && k == 0) begin
                // R7 and R11: mode flip and timing rewrite mid-access
                slow = ~slow;
                cfg_wr = 1'b1; cfg_cs = 2'(cs); cfg_field = 4'(base + 4); cfg_val = 6'd7;
            end
            if (k == 1) cfg_wr = 1'b0;
            if (!we && tw > 0 && ts < c && k == last) exp_rd = rv(k);
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        chk("R3", "ack after last cycle", 64'(ack), 64'd1);
        chk("R3", "idle pins in ack cycle", {59'd0, cs_n, rd_n & wr_n}, {59'd0, 4'hF, 1'b1});
        chk("R9", "enable off after access", 64'(oe), 64'd0);
        if (!we) chk("R10", "captured read data", 64'(rdata), 64'(exp_rd));
        @(negedge clk);
        chk("R3", "ack one cycle", 64'(ack), 64'd0);
        if (disturb) begin
            slow = ~slow;
            sh[cs][base + 4] = 7;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        for (int i = 0; i < 4; i++) begin
            // R12: reset contents equal the fixed slow set
            sh[i][0] = 2; sh[i][1] = 0; sh[i][2] = 2; sh[i][3] = 1; sh[i][4] = 1;
            sh[i][5] = 3; sh[i][6] = 0; sh[i][7] = 3; sh[i][8] = 1; sh[i][9] = 1;
        end
        repeat (3) @(negedge clk);
        chk("R1", "pins in reset", {57'd0, cs_n, rd_n, wr_n, ack, oe},
            {57'd0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pins after reset", {57'd0, cs_n, rd_n, wr_n, ack, oe},
            {57'd0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0});

        // R12: normal mode with untouched registers
        do_access(1'b0, 0, 24'h000100, 4'hF, 32'h0, 1'b0);
        do_access(1'b1, 1, 24'h000204, 4'h3, 32'hCAFE_0001, 1'b0);

        // R2 directed read with capture mid-cycle (R10)
        write_cfg(2, 0, 6); write_cfg(2, 1, 1); write_cfg(2, 2, 4);
        write_cfg(2, 3, 2); write_cfg(2, 4, 2);
        do_access(1'b0, 2, 24'h00ABC0, 4'hC, 32'h0, 1'b0);
        // strobe longer than cycle: cut at cycle end, capture at last cycle
        write_cfg(2, 0, 3); write_cfg(2, 4, 5);
        do_access(1'b0, 2, 24'h00ABC4, 4'h1, 32'h0, 1'b0);
        // cycle count zero acts as one
        write_cfg(3, 5, 0); write_cfg(3, 8, 0); write_cfg(3, 9, 2);
        do_access(1'b1, 3, 24'h123456, 4'h8, 32'h0BAD_F00D, 1'b0);
        // R10: zero-width read strobe keeps the old data
        write_cfg(3, 0, 4); write_cfg(3, 4, 0);
        do_access(1'b0, 3, 24'h000010, 4'hF, 32'h0, 1'b0);
        // R11: reserved codes change nothing
        for (int f = 10; f < 16; f++) write_cfg(2, f, 63);
        do_access(1'b0, 2, 24'h00ABC8, 4'h2, 32'h0, 1'b0);

        // R4/R5/R6: slow mode over odd programmed values on every region
        for (int r = 0; r < 4; r++) begin
            write_cfg(r, 0, 9); write_cfg(r, 5, 11); write_cfg(r, 4, 5); write_cfg(r, 8, 4);
        end
        slow = 1'b1;
        for (int r = 0; r < 4; r++) begin
            do_access(1'b0, r, 24'(32'h1000 + r), 4'hF, 32'h0, 1'b0);
            do_access(1'b1, r, 24'(32'h2000 + r), 4'h5, 32'(32'h7700 + r), 1'b0);
        end
        // R7: flip mode and rewrite timing during an access
        do_access(1'b0, 1, 24'h003000, 4'hF, 32'h0, 1'b1);
        slow = 1'b0;
        do_access(1'b1, 2, 24'h003004, 4'hA, 32'h1357_9BDF, 1'b1);
        do_access(1'b0, 0, 24'h003008, 4'hF, 32'h0, 1'b1);

        // Constrained random mix
        for (int n = 0; n < 200; n++) begin
            if ($urandom_range(0, 9) < 3) begin
                int fld;
                fld = $urandom_range(0, 9);
                write_cfg($urandom_range(0, 3), fld,
                          (fld % 5 == 0) ? $urandom_range(0, 9) : $urandom_range(0, 4));
            end else begin
                slow = ($urandom_range(0, 3) == 0);
                do_access(1'($urandom_range(0, 1)), $urandom_range(0, 3), 24'($urandom),
                          4'($urandom), $urandom, 1'($urandom_range(0, 7) == 0));
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule